// File: doc/BRIEF.md
# Streaming 3x3 Window Line Buffer

This block sits in front of a 3x3 convolution or filter stage. It takes a raster-scanned image one pixel per clock, row after row with rows placed end to end, and after every accepted pixel it offers a full 3x3 neighbourhood together with the row and column of that neighbourhood's centre. The downstream stage can then compute one output per clock without reading any pixel more than once from memory.

Storage is one linear shift chain of 2W+3 pixels, where W is the image row width. Because the chain spans just over two rows, nine fixed taps on it always hold three horizontally adjacent pixels from each of the three most recent rows. The chain takes the place of an addressed cache, which would need nine reads and one write for every pixel. Edge handling is left to the consumer. Any neighbourhood that would reach past an image edge is marked not valid and should be dropped. A frame-start strobe restarts position tracking for each new image. It leaves the stored pixels in place.

Top module: `lb3_window`

## Requirements
- R1: Each valid window holds the 3x3 neighbourhood of the current frame centred on (cen_row, cen_col): the pixel at row cen_row-1+i, column cen_col-1+j, where i and j run from 0 to 2.
- R2: When in_valid is high at a clock edge, the pixel is accepted and the window outputs for that pixel appear right after that same edge, so one window decision is made per accepted pixel.
- R3: win_valid is high only if at least 2W+3 pixels have been accepted since the frame start, and only if the centre column lies between 1 and W-2 inclusive. Under those conditions it is always high.
- R4: For the pixel accepted at row r and column c, cen_row equals r-1 (modulo 2^ROW_BITS) and cen_col equals c-1. Positions count in raster order from 0, and the row advances after column W-1.
- R5: A cycle with in_valid low accepts nothing. win_valid is low after it, and win_pix keeps its previous value.
- R6: sof high together with in_valid makes that pixel position (0,0) of a new frame. sof high with in_valid low makes the next accepted pixel position (0,0). Neither case clears the stored pixels.
- R7: A synchronous active-high rst drives win_valid low and makes the next accepted pixel position (0,0).
- R8: win_pix packs the nine pixels with slot k = 3*i + j in bits [k*PIX_W +: PIX_W]. Slot 0 is the top-left (oldest) pixel and slot 8 is the bottom-right (newest) pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Frame-start strobe |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | PIX_W | Input pixel, raster order |
| win_valid | output | 1 | Window is complete and inside the image |
| win_pix | output | 9*PIX_W | Nine window pixels, slot 0 top-left |
| cen_row | output | ROW_BITS | Row of the window centre |
| cen_col | output | $clog2(ROW_W) | Column of the window centre |

## Verification
A tap index that is off by one would put a neighbour from the wrong row or column into win_pix. That shows up on the very first valid window of a frame, at the 2W+3rd pixel. A column or fill counter that drifts would shift the win_valid pattern or the centre coordinates within a single row. An enable that leaks into an idle cycle would change win_pix during a gap in the input. The bench checks every cycle against a behavioural frame model, so any of these faults is reported in the cycle where it first appears.

// File: rtl/lb3_pkg.sv
package lb3_pkg;
  // Chain index feeding window slot (wr, wc); wr/wc = 0 is top/left.
  function automatic int tap_index(input int row_w, input int wr, input int wc);
    return (2 - wr) * row_w + (2 - wc);
  endfunction
endpackage

// File: rtl/lb3_shift.sv
module lb3_shift #(
  parameter int PIX_W = 8,
  parameter int ROW_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic [PIX_W-1:0]   din,
  output logic [9*PIX_W-1:0] win
);
  import lb3_pkg::*;
  localparam int DEPTH = 2 * ROW_W + 3;

  logic [PIX_W-1:0] chain [DEPTH];

  // Not reset: contents only matter once the fill count qualifies them.
  always_ff @(posedge clk) begin
    if (shift_en) begin
      chain[0] <= din;
      for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
    end
  end

  for (genvar k = 0; k < 9; k++) begin : g_tap
    assign win[k*PIX_W +: PIX_W] = chain[tap_index(ROW_W, k / 3, k % 3)];
  end

  // R1
  head_load_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> win[8*PIX_W +: PIX_W] == $past(din));
  // R1
  tail_move_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> chain[DEPTH-1] == $past(chain[DEPTH-2]));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(win));
endmodule

// File: rtl/lb3_track.sv
module lb3_track #(
  parameter int ROW_W    = 8,
  parameter int ROW_BITS = 10,
  localparam int COL_BITS = $clog2(ROW_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                sof,
  output logic                win_valid,
  output logic [ROW_BITS-1:0] cen_row,
  output logic [COL_BITS-1:0] cen_col
);
  localparam int FILL      = 2 * ROW_W + 3;
  localparam int FILL_BITS = $clog2(FILL + 1);

  logic [COL_BITS-1:0]  nxt_col, cur_col;
  logic [ROW_BITS-1:0]  nxt_row, cur_row;
  logic [FILL_BITS-1:0] fill, cur_fill, fill_inc;
  logic                 row_end;

  always_comb begin
    cur_col  = sof ? '0 : nxt_col;
    cur_row  = sof ? '0 : nxt_row;
    cur_fill = sof ? '0 : fill;
    fill_inc = (cur_fill == FILL_BITS'(FILL)) ? cur_fill : cur_fill + 1'b1;
    row_end  = (cur_col == COL_BITS'(ROW_W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_col   <= '0;
      nxt_row   <= '0;
      fill      <= '0;
      win_valid <= 1'b0;
      cen_row   <= '0;
      cen_col   <= '0;
    end else if (in_valid) begin
      nxt_col   <= row_end ? '0 : cur_col + 1'b1;
      nxt_row   <= row_end ? cur_row + 1'b1 : cur_row;
      fill      <= fill_inc;
      win_valid <= (fill_inc == FILL_BITS'(FILL)) && (cur_col >= COL_BITS'(2));
      cen_row   <= cur_row - 1'b1;
      cen_col   <= cur_col - 1'b1;
    end else begin
      win_valid <= 1'b0;
      if (sof) begin
        nxt_col <= '0;
        nxt_row <= '0;
        fill    <= '0;
      end
    end
  end

  // R3
  centre_col_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (cen_col >= COL_BITS'(1)) && (cen_col <= COL_BITS'(ROW_W - 2)));
  // R3
  centre_row_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> cen_row != '1);
  // R5
  idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !win_valid);
  // R6
  new_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sof) |=> !win_valid && cen_col == '1);
  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sof && $past(in_valid) && !$past(sof) && $past(!rst) && win_valid)
      |=> cen_col == $past(cen_col) + 1'b1 || cen_col == '1);
endmodule

// File: rtl/lb3_window.sv
module lb3_window #(
  parameter int PIX_W    = 8,
  parameter int ROW_W    = 8,
  parameter int ROW_BITS = 10,
  localparam int COL_BITS = $clog2(ROW_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sof,
  input  logic                in_valid,
  input  logic [PIX_W-1:0]    in_pix,
  output logic                win_valid,
  output logic [9*PIX_W-1:0]  win_pix,
  output logic [ROW_BITS-1:0] cen_row,
  output logic [COL_BITS-1:0] cen_col
);
  lb3_shift #(.PIX_W(PIX_W), .ROW_W(ROW_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (in_valid),
    .din      (in_pix),
    .win      (win_pix)
  );

  lb3_track #(.ROW_W(ROW_W), .ROW_BITS(ROW_BITS)) u_track (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sof       (sof),
    .win_valid (win_valid),
    .cen_row   (cen_row),
    .cen_col   (cen_col)
  );
endmodule

// File: tb/test_lb3_window.sv
module test_lb3_window;
  localparam int PIX_W = 8;
  localparam int W     = 8;
  localparam int RB    = 6;
  localparam int CB    = $clog2(W);

  logic clk = 1'b0, rst = 1'b1, sof = 1'b0, in_valid = 1'b0;
  logic [PIX_W-1:0]   in_pix = '0;
  logic               win_valid;
  logic [9*PIX_W-1:0] win_pix, prev_win;
  logic [RB-1:0]      cen_row;
  logic [CB-1:0]      cen_col;

  int checks = 0, fails = 0, n = 0;
  int frame [0:1023];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lb3_window #(.PIX_W(PIX_W), .ROW_W(W), .ROW_BITS(RB)) i_lb3_window (
    .clk(clk), .rst(rst), .sof(sof), .in_valid(in_valid), .in_pix(in_pix),
    .win_valid(win_valid), .win_pix(win_pix), .cen_row(cen_row), .cen_col(cen_col)
  );

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit s, input int pix);
    logic [9*PIX_W-1:0] e;
    int idx, cr, cc;
    bit ev;
    @(negedge clk);
    in_valid = v; sof = s; in_pix = PIX_W'(pix);
    @(posedge clk); #1;
    if (s) n = 0;
    if (v) begin
      idx = n; frame[idx] = pix & 255; n++;
      ev = (idx >= 2*W + 2) && (idx % W >= 2);       // R3
      cr = idx / W - 1; cc = idx % W - 1;
      chk(win_valid == ev, "R2/R3 win_valid", 72'(win_valid), 72'(ev));
      if (ev) begin
        chk(cen_row == RB'(cr), "R4 cen_row", 72'(cen_row), 72'(cr));
        chk(cen_col == CB'(cc), "R4 cen_col", 72'(cen_col), 72'(cc));
        for (int k = 0; k < 9; k++)
          e[k*PIX_W +: PIX_W] = PIX_W'(frame[(cr - 1 + k/3) * W + cc - 1 + k%3]);
        chk(win_pix == e, "R1/R8 win_pix", win_pix, e);
      end
    end else begin
      chk(win_valid == 1'b0, "R5 idle win_valid", 72'(win_valid), 72'(0));
      chk(win_pix == prev_win, "R5 idle hold", win_pix, prev_win);
    end
    prev_win = win_pix;
    in_valid = 1'b0; sof = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0; sof = 1'b0;
    repeat (2) @(posedge clk);
    #1; chk(win_valid == 1'b0, "R7 reset win_valid", 72'(win_valid), 72'(0));
    @(negedge clk); rst = 1'b0;
    n = 0; prev_win = win_pix;
  endtask

  initial begin
    int lfsr;
    do_reset();
    // Frame A: continuous stream
    for (int i = 0; i < 6*W; i++) step(1'b1, i == 0, (i*37 + 11) & 255);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0);
    // Frame B: gaps in the input
    lfsr = 32'h5a;
    for (int i = 0; i < 5*W; i++) begin
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      if ((lfsr >> 16) % 3 == 0) step(1'b0, 1'b0, 0);
      step(1'b1, i == 0, (lfsr >> 8) & 255);
    end
    // R6: restart with sof+valid mid-frame
    for (int i = 0; i < 13; i++) step(1'b1, i == 0, i + 100);
    for (int i = 0; i < 4*W; i++) step(1'b1, i == 0, (i*53 + 7) & 255);
    // R6: sof alone restarts counting
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, i + 200);
    step(1'b0, 1'b1, 0);
    for (int i = 0; i < 4*W; i++) step(1'b1, 1'b0, (i*91 + 3) & 255);
    // R7: reset mid-frame, then a frame with no sof
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, i);
    do_reset();
    for (int i = 0; i < 4*W; i++) step(1'b1, 1'b0, (i*29 + 5) & 255);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule